// File: doc/BRIEF.md
# Edge-Triggered GPIO Interrupt Register Block

This block serves a bank of sixteen general-purpose pins through a small register file on a simple synchronous bus. Each pin can drive an output or be read back as an input. Every input passes through a two-stage synchronizer. Rising and falling transitions on the synchronized level are detected separately. An edge whose enable bit is set latches a sticky status bit. Software clears that bit by writing a one to it. A single interrupt line is raised while any latched event is also enabled. Card-ready and card-detect lines are wired to ordinary pins, and their falling edges are reported through the falling-status register.

The register file holds 16-bit words. After reset they appear big-endian on the bus: register bits 15:8 travel on bus lanes 7:0. A swap-select bit in the control word turns this lane exchange on or off, for writes and for reads. Because that bit can be written and read back, software can use it to confirm that the block is present. The control word also carries an output-drive enable, a card enable and a mode bit.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset the control word reads 0x0001 (lane swap on, every other bit clear). Direction, output data, both enable words and both status words read 0, gpio_oe is 0 and irq is 0.
- R2: While control bit 0 (swap) is 1, bus lanes 7:0 carry register bits 15:8 and bus lanes 15:8 carry register bits 7:0, on both write data and read data. While it is 0 the mapping is straight. The bit can be written and read back.
- R3: gpio_out always equals the output-data register. gpio_oe equals the direction register (1 = output) ANDed bitwise with control bit 1 (drive enable).
- R4: The data-in register returns the pins two clocks after they change. A pin driven after one rising edge is visible after the second rising edge that follows. Writes to data-in have no effect.
- R5: A 0-to-1 change on the synchronized level of pin i sets rising-status bit i exactly one clock after it first reads in data-in, provided rising-enable bit i is 1. With the enable at 0 the bit stays clear.
- R6: A 1-to-0 change on the synchronized level of pin i sets falling-status bit i under falling-enable bit i, with the same timing as R5.
- R7: Writing a status word clears each bit written as 1. Bits written as 0 keep their value.
- R8: If an enabled edge and a clear hit the same status bit in the same clock, the bit ends set.
- R9: irq is 1 exactly when (rising-status AND rising-enable) OR (falling-status AND falling-enable) is non-zero. Clearing an enable drops irq but keeps the status bit.
- R10: Control bit 2 drives card_en and control bit 3 drives mode_sel. Both read back. Control bits 15:4 read as 0.
- R11: Register addresses are: 0 control, 1 direction, 2 data-in, 3 output data, 4 rising enable, 5 falling enable, 6 rising status, 7 falling status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data, in bus lane order |
| bus_rdata | output | 16 | Read data, in bus lane order, combinational from the address |
| gpio_in | input | 16 | Asynchronous pin levels |
| gpio_out | output | 16 | Pin output values |
| gpio_oe | output | 16 | Pin output enables |
| card_en | output | 1 | Card enable from control bit 2 |
| mode_sel | output | 1 | Mode from control bit 3 |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is R8: a status write that lands in the same clock as the hardware edge on the bit it clears. The stimulus first latches the bit with a previous edge and lets the pin fall back. It then raises the pin and issues the clear write exactly two clocks later, so that the write edge is also the edge on which the detector reports the new rise. A neighbouring bit cleared by the same write shows that the write itself took effect. The pin sweep walks each of the sixteen pins through both polarities against shifted enable masks, and computes the expected status and interrupt from the masks.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int REG_W  = 16;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 3'd0,
        A_DIR  = 3'd1,
        A_DIN  = 3'd2,
        A_DOUT = 3'd3,
        A_REN  = 3'd4,
        A_FEN  = 3'd5,
        A_RST  = 3'd6,
        A_FST  = 3'd7
    } reg_addr_e;

    // control word bits 3..0
    typedef struct packed {
        logic mode;
        logic card_en;
        logic drv_en;
        logic swap;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/gpio_lane_swap.sv
module gpio_lane_swap #(
    parameter int W = 16
) (
    input  logic         swap_i,
    input  logic [W-1:0] a_i,
    output logic [W-1:0] y_o
);
    localparam int NB = W / 8;

    logic [W-1:0] rev;

    generate
        for (genvar b = 0; b < NB; b++) begin : g_byte
            assign rev[b*8 +: 8] = a_i[(NB-1-b)*8 +: 8];
        end
    endgenerate

    assign y_o = swap_i ? rev : a_i;
endmodule

// File: rtl/gpio_sync_edge.sv
module gpio_sync_edge #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
        logic [W-1:0]             prev;
        logic [1:0]               age;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = pin_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.chain[s] = st_q.chain[s-1];
        end
        st_d.prev = st_q.chain[STAGES-1];
        if (st_q.age != 2'd3) begin
            st_d.age = st_q.age + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.chain[STAGES-1];
    assign rise_o  = level_o & ~st_q.prev;
    assign fall_o  = ~level_o & st_q.prev;

    generate
        if (STAGES == 2) begin : g_chk
            // R4: synchronized level equals the pin two samples back
            a_r4_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.age >= 2'd2) |-> (level_o == $past(pin_i, 2)));
        end
    endgenerate
endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] event_i,
    input  logic [W-1:0] en_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] stat_o
);
    logic [W-1:0] stat_d, stat_q, hit;

    assign hit = event_i & en_i;

    always_comb begin
        stat_d = (stat_q & ~clr_i) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign stat_o = stat_q;

    // R5 / R6 / R8: an enabled edge always leaves its bit set
    a_r5_edge_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (|(event_i & en_i)) |=> ((stat_o & $past(event_i & en_i)) == $past(event_i & en_i)));

    // R7: written ones without a coincident edge clear
    a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_i) |=> ((stat_o & $past(clr_i & ~(event_i & en_i))) == '0));

    // R7: untouched bits keep their value
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i | (event_i & en_i)) == '0) |=> $stable(stat_o));
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
    import gpio_irq_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      gpio_in,
    output logic [W-1:0]      gpio_out,
    output logic [W-1:0]      gpio_oe,
    output logic              card_en,
    output logic              mode_sel,
    output logic              irq
);
    typedef struct packed {
        ctrl_t        ctrl;
        logic [W-1:0] dir;
        logic [W-1:0] dout;
        logic [W-1:0] ren;
        logic [W-1:0] fen;
    } cfg_st_t;

    localparam cfg_st_t CFG_RST = '{ctrl: '{mode: 1'b0, card_en: 1'b0, drv_en: 1'b0, swap: 1'b1},
                                    default: '0};

    cfg_st_t cfg_d, cfg_q;

    logic [W-1:0] wr_val, rd_val;
    logic [W-1:0] level, rise, fall;
    logic [W-1:0] rclr, fclr, rstat, fstat;
    logic         wr_hit;
    reg_addr_e    addr;

    assign addr   = reg_addr_e'(bus_addr);
    assign wr_hit = bus_en & bus_we;

    gpio_lane_swap #(.W(W)) u_wswap (
        .swap_i (cfg_q.ctrl.swap),
        .a_i    (bus_wdata),
        .y_o    (wr_val)
    );

    gpio_sync_edge #(.W(W), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (gpio_in),
        .level_o (level),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    always_comb begin
        cfg_d = cfg_q;
        rclr  = '0;
        fclr  = '0;
        if (wr_hit) begin
            unique case (addr)
                A_CTRL:  cfg_d.ctrl = ctrl_t'(wr_val[CTRL_W-1:0]);
                A_DIR:   cfg_d.dir  = wr_val;
                A_DOUT:  cfg_d.dout = wr_val;
                A_REN:   cfg_d.ren  = wr_val;
                A_FEN:   cfg_d.fen  = wr_val;
                A_RST:   rclr       = wr_val;
                A_FST:   fclr       = wr_val;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_RST;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    gpio_edge_status #(.W(W)) u_rise (
        .clk     (clk),
        .rst_n   (rst_n),
        .event_i (rise),
        .en_i    (cfg_q.ren),
        .clr_i   (rclr),
        .stat_o  (rstat)
    );

    gpio_edge_status #(.W(W)) u_fall (
        .clk     (clk),
        .rst_n   (rst_n),
        .event_i (fall),
        .en_i    (cfg_q.fen),
        .clr_i   (fclr),
        .stat_o  (fstat)
    );

    always_comb begin
        rd_val = '0;
        unique case (addr)
            A_CTRL:  rd_val[CTRL_W-1:0] = cfg_q.ctrl;
            A_DIR:   rd_val = cfg_q.dir;
            A_DIN:   rd_val = level;
            A_DOUT:  rd_val = cfg_q.dout;
            A_REN:   rd_val = cfg_q.ren;
            A_FEN:   rd_val = cfg_q.fen;
            A_RST:   rd_val = rstat;
            A_FST:   rd_val = fstat;
            default: ;
        endcase
    end

    gpio_lane_swap #(.W(W)) u_rswap (
        .swap_i (cfg_q.ctrl.swap),
        .a_i    (rd_val),
        .y_o    (bus_rdata)
    );

    assign gpio_out = cfg_q.dout;
    assign gpio_oe  = cfg_q.dir & {W{cfg_q.ctrl.drv_en}};
    assign card_en  = cfg_q.ctrl.card_en;
    assign mode_sel = cfg_q.ctrl.mode;
    assign irq      = (|(rstat & cfg_q.ren)) | (|(fstat & cfg_q.fen));

    // R9: an enabled pending bit seen on one edge keeps irq up on the next
    //     unless software changed registers in between
    a_r9_irq_persists: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_hit) |=> irq);
endmodule

// File: tb/sim_gpio_edge_irq.sv
module sim_gpio_edge_irq;
    localparam int TCLK  = 10;
    localparam int LIMIT = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0, bus_rdata;
    logic [15:0] gpio_in = '0, gpio_out, gpio_oe;
    logic        card_en, mode_sel, irq;

    int total = 0, bad = 0, cyc = 0;
    bit sw = 1'b1, done = 1'b0;

    gpio_edge_irq u0 (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
        .card_en(card_en), .mode_sel(mode_sel), .irq(irq)
    );

    always #(TCLK/2) clk = ~clk;

    function automatic logic [15:0] bswap(input logic [15:0] v);
        return {v[7:0], v[15:8]};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == LIMIT) begin
            total++;
            bad++;
            $display("FAIL watchdog (R1..) actual=%0d expected<%0d", cyc, LIMIT);
            finish_run();
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] v);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a;
        bus_wdata = sw ? bswap(v) : v;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        if (a == 3'd0) sw = v[0];
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        v = sw ? bswap(bus_rdata) : bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic rd_raw(input logic [2:0] a, output logic [15:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wait_n(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        logic [15:0] v, re, fe, bit_i, pat;
        wait_n(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state; R2 raw big-endian view of control
        rd_raw(3'd0, v); check("R1/R2 ctrl raw", v, 16'h0100);
        for (int a = 1; a < 8; a++) begin
            rd(a[2:0], v); check("R1 reg zero", v, 16'h0000);
        end
        check("R1 oe", gpio_oe, 16'h0000);
        check("R1 irq", {15'd0, irq}, 16'h0000);

        // R2 swapped write/read, R3 output data
        wr(3'd3, 16'h1234);
        check("R3 gpio_out", gpio_out, 16'h1234);
        rd_raw(3'd3, v); check("R2 swapped read", v, 16'h3412);

        // R2 swap off, R10 card enable
        wr(3'd0, 16'h0006);
        rd_raw(3'd0, v); check("R2 swap off ctrl", v, 16'h0006);
        rd_raw(3'd3, v); check("R2 straight read", v, 16'h1234);
        check("R10 card_en", {15'd0, card_en}, 16'h0001);
        wr(3'd1, 16'hF0F0);
        check("R3 oe driven", gpio_oe, 16'hF0F0);
        wr(3'd0, 16'hFFFA);
        rd(3'd0, v); check("R10 upper bits zero", v, 16'h000A);
        check("R10 mode_sel", {14'd0, mode_sel, card_en}, 16'h0002);
        wr(3'd0, 16'h0000);
        check("R3 oe gated", gpio_oe, 16'h0000);

        // R4 sync delay and ignored write
        @(negedge clk); gpio_in = 16'hBEEF;
        @(negedge clk); rd(3'd2, v); check("R4 not yet", v, 16'h0000);
        @(negedge clk); rd(3'd2, v); check("R4 two clocks", v, 16'hBEEF);
        wr(3'd2, 16'h0000);
        rd(3'd2, v); check("R4 write ignored", v, 16'hBEEF);
        gpio_in = 16'h0000; wait_n(4);

        // R5/R6/R9 sweep of every pin against shifted enable masks
        for (int i = 0; i < 16; i++) begin
            re = 16'hFFFF << i;
            fe = ~(16'hFFFF << ((i + 1) % 16)) ^ 16'h8000;
            bit_i = 16'h0001 << i;
            wr(3'd4, re); wr(3'd5, fe);
            @(negedge clk); gpio_in = bit_i;
            wait_n(3);
            rd(3'd6, v); check("R5 rise status", v, bit_i & re);
            rd(3'd7, v); check("R6 no fall", v, 16'h0000);
            check("R9 irq rise", {15'd0, irq}, {15'd0, |(bit_i & re)});
            gpio_in = 16'h0000;
            wait_n(3);
            rd(3'd7, v); check("R6 fall status", v, bit_i & fe);
            wr(3'd6, 16'hFFFF); wr(3'd7, 16'hFFFF);
            rd(3'd6, v); check("R7 cleared", v, 16'h0000);
        end

        // R5 multi-pin pattern, R7 partial clear and zero write
        pat = 16'hA5C3;
        wr(3'd4, 16'hFFFF); wr(3'd5, 16'h0000);
        @(negedge clk); gpio_in = pat; wait_n(3);
        rd(3'd6, v); check("R5 pattern", v, pat);
        wr(3'd6, 16'h0003);
        rd(3'd6, v); check("R7 ones clear", v, pat & ~16'h0003);
        wr(3'd6, 16'h0000);
        rd(3'd6, v); check("R7 zeros keep", v, pat & ~16'h0003);
        // R9 clearing enable drops irq but keeps status
        wr(3'd4, 16'h0000);
        check("R9 irq off", {15'd0, irq}, 16'h0000);
        rd(3'd6, v); check("R9 status kept", v, pat & ~16'h0003);
        wr(3'd6, 16'hFFFF);
        gpio_in = 16'h0000; wait_n(4);

        // R8 edge and clear in the same clock
        wr(3'd4, 16'h0003);
        @(negedge clk); gpio_in = 16'h0003; wait_n(3);
        gpio_in = 16'h0000; wait_n(4);
        rd(3'd6, v); check("R8 setup", v, 16'h0003);
        gpio_in = 16'h0001;
        @(negedge clk);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = 3'd6; bus_wdata = 16'h0003;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        rd(3'd6, v); check("R8 edge wins", v, 16'h0001);

        // R11 address decode: falling status at 7 via card-style pins
        wr(3'd5, 16'h0300);
        @(negedge clk); gpio_in = 16'h0301; wait_n(4);
        gpio_in = 16'h0001; wait_n(4);
        rd(3'd7, v); check("R11/R6 fall at addr 7", v, 16'h0300);
        check("R9 irq fall", {15'd0, irq}, 16'h0001);

        finish_run();
    end
endmodule